// File: doc/BRIEF.md
# Wide-Bank Cartridge Bank Controller

This block sits between an 8-bit console's 16-bit address bus and a cartridge's ROM and external RAM chips. It decodes CPU writes to the ROM address space as register updates and drives the upper address lines of both memories from what it holds. The ROM bank number is nine bits wide and is loaded in two parts. A write to one range sets the low byte. A write to a second range sets the top bit.

The switchable ROM window at 0x4000–0x7FFF shows whichever bank is selected, and bank 0 is a legal choice there. The fixed window at 0x0000–0x3FFF always drives zeros on the bank lines. A 4-bit RAM bank selects which part of external RAM appears at 0xA000–0xBFFF. Access to that RAM is allowed only after a key byte has been written to the enable range. While RAM access is off, the RAM chip select stays high and CPU reads from the window return 0xFF. The block has no clock function and no clock latch range.

Top module: `wbank_ctrl`

## Requirements
- R1: After reset, the ROM bank is 1 (`rom_hi` reads 1 in the switchable window), the RAM bank is 0 (`ram_hi` is 0) and RAM access is off.
- R2: A write with `cpu_addr[15:12]` equal to 4'h2 loads `cpu_wdata` into bits 7:0 of the ROM bank. The value appears on `rom_hi[7:0]` for accesses with `cpu_addr[15:14]` equal to 2'b01 from the cycle after the write.
- R3: A write with `cpu_addr[15:12]` equal to 4'h3 loads only `cpu_wdata[0]` into ROM bank bit 8 (`rom_hi[8]`). Data bits 7:1 have no effect.
- R4: Bank 0 (low byte 0 and high bit 0) puts 0 on `rom_hi` in the switchable window. It is not replaced by bank 1.
- R5: While `cpu_addr[15:14]` is 2'b00, `rom_hi` is 0 whatever bank is held.
- R6: A write with `cpu_addr[15:13]` equal to 3'b010 loads `cpu_wdata[3:0]` into the RAM bank, which drives `ram_hi`. Data bits 7:4 are ignored.
- R7: A write with `cpu_addr[15:13]` equal to 3'b000 turns RAM access on when the data is exactly 8'h0A. Any other data byte turns it off.
- R8: For an access with `cpu_addr[15:13]` equal to 3'b101, `ram_cs_n` goes low only when RAM access is on. `cpu_rdata` returns `ram_q` when access is on and 8'hFF when it is off.
- R9: `rom_cs_n` is low only for reads with `cpu_addr[15]` equal to 0. Writes with `cpu_addr[15:13]` equal to 3'b011, and addresses 0x8000 and above outside the RAM window, change no register. Reads outside the RAM window return `rom_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe; registers are updated at the clock edge |
| cpu_rd | input | 1 | Read strobe |
| rom_q | input | 8 | Data returned by the ROM |
| ram_q | input | 8 | Data returned by the RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_hi | output | 9 | ROM address bits 22:14 |
| ram_hi | output | 4 | RAM address bits 16:13 |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together and that `cpu_addr` and `cpu_wdata` hold steady through the clock edge of a write. Each write-effect property is also waived when the following cycle leaves the window in which the effect can be seen. The stimulus meets these assumptions in two ways. Every input change happens on the falling edge. Each write is a single-cycle strobe that returns to idle before any read probe.

// File: rtl/wbank_ctrl.sv
module wbank_ctrl #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter logic [7:0] RAM_KEY = 8'h0A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic                  cpu_wr,
  input  logic                  cpu_rd,
  input  logic [7:0]            rom_q,
  input  logic [7:0]            ram_q,
  output logic [7:0]            cpu_rdata,
  output logic [ROM_BANK_W-1:0] rom_hi,
  output logic [RAM_BANK_W-1:0] ram_hi,
  output logic                  rom_cs_n,
  output logic                  ram_cs_n
);
  localparam int HI_W = ROM_BANK_W - 8;

  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_on;

  wire sel_en   = cpu_addr[15:13] == 3'b000;
  wire sel_lo   = cpu_addr[15:12] == 4'h2;
  wire sel_hi   = cpu_addr[15:12] == 4'h3;
  wire sel_ramb = cpu_addr[15:13] == 3'b010;
  wire win_sw   = cpu_addr[15:14] == 2'b01;
  wire win_ram  = cpu_addr[15:13] == 3'b101;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= ROM_BANK_W'(1);
      ram_bank <= '0;
      ram_on   <= 1'b0;
    end else if (cpu_wr) begin
      if (sel_en)   ram_on <= (cpu_wdata == RAM_KEY);
      if (sel_lo)   rom_bank[7:0] <= cpu_wdata;
      if (sel_hi)   rom_bank[ROM_BANK_W-1:8] <= cpu_wdata[HI_W-1:0];
      if (sel_ramb) ram_bank <= cpu_wdata[RAM_BANK_W-1:0];
    end
  end

  assign rom_hi    = win_sw ? rom_bank : '0;
  assign ram_hi    = ram_bank;
  assign rom_cs_n  = ~(cpu_rd & ~cpu_addr[15]);
  assign ram_cs_n  = ~((cpu_rd | cpu_wr) & win_ram & ram_on);
  assign cpu_rdata = win_ram ? (ram_on ? ram_q : 8'hFF) : rom_q;
endmodule

module wbank_ctrl_chk #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter logic [7:0] RAM_KEY = 8'h0A
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic                  cpu_wr,
  input logic                  cpu_rd,
  input logic [7:0]            cpu_rdata,
  input logic [ROM_BANK_W-1:0] rom_hi,
  input logic [RAM_BANK_W-1:0] ram_hi,
  input logic                  rom_cs_n,
  input logic                  ram_cs_n
);
  localparam int HI_W = ROM_BANK_W - 8;

  wire in_sw  = cpu_addr[15:14] == 2'b01;
  wire in_ram = cpu_addr[15:13] == 3'b101;

  p_low_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h2) |=> (!in_sw || rom_hi[7:0] == $past(cpu_wdata)));

  p_high_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h3) |=>
      (!in_sw || rom_hi[ROM_BANK_W-1:8] == $past(cpu_wdata[HI_W-1:0])));

  p_fixed_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (rom_hi == '0));

  p_ram_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b010) |=> (ram_hi == $past(cpu_wdata[RAM_BANK_W-1:0])));

  p_bad_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata != RAM_KEY) |=> ram_cs_n);

  p_ram_off_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && ram_cs_n && cpu_rd) |-> (cpu_rdata == 8'hFF));

  p_ram_cs_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> (in_ram && (cpu_rd || cpu_wr)));

  p_rom_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> (cpu_rd && !cpu_addr[15]));
endmodule

bind wbank_ctrl wbank_ctrl_chk #(
  .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W), .RAM_KEY(RAM_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_hi(rom_hi),
  .ram_hi(ram_hi), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
);

// File: tb/sim_wbank_ctrl.sv
`timescale 1ns/1ps
module sim_wbank_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 0;
  logic        cpu_rd = 0;
  logic [7:0]  rom_q = 8'hC3;
  logic [7:0]  ram_q = 8'h5A;
  logic [7:0]  cpu_rdata;
  logic [8:0]  rom_hi;
  logic [3:0]  ram_hi;
  logic        rom_cs_n, ram_cs_n;

  always #2 clk = ~clk;

  wbank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_q(rom_q), .ram_q(ram_q),
    .cpu_rdata(cpu_rdata), .rom_hi(rom_hi), .ram_hi(ram_hi),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  typedef struct {
    logic [8:0] rom_hi;
    logic [3:0] ram_hi;
    logic       rom_cs_n;
    logic       ram_cs_n;
    logic [7:0] rdata;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [8:0] m_bank;
  logic [3:0] m_ramb;
  bit         m_on;

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1; cpu_rd = 0;
    @(negedge clk);
    cpu_wr = 0;
    if (a[15:13] == 3'b000) m_on = (d == 8'h0A);
    if (a[15:12] == 4'h2) m_bank[7:0] = d;
    if (a[15:12] == 4'h3) m_bank[8] = d[0];
    if (a[15:13] == 3'b010) m_ramb = d[3:0];
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    exp_t e;
    bit rw;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1; cpu_wr = 0;
    rw = (a[15:13] == 3'b101);
    e.rom_hi   = (a[15:14] == 2'b01) ? m_bank : 9'd0;
    e.ram_hi   = m_ramb;
    e.rom_cs_n = a[15];
    e.ram_cs_n = !(rw && m_on);
    e.rdata    = rw ? (m_on ? ram_q : 8'hFF) : rom_q;
    e.tag      = tag;
    sb.push_back(e);
    @(negedge clk);
    cpu_rd = 0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rom_hi !== e.rom_hi || ram_hi !== e.ram_hi || rom_cs_n !== e.rom_cs_n ||
            ram_cs_n !== e.ram_cs_n || cpu_rdata !== e.rdata) begin
          fails++;
          $display("FAIL %s: got rom_hi=%h ram_hi=%h rom_cs_n=%b ram_cs_n=%b rdata=%h exp %h %h %b %b %h",
                   e.tag, rom_hi, ram_hi, rom_cs_n, ram_cs_n, cpu_rdata,
                   e.rom_hi, e.ram_hi, e.rom_cs_n, e.ram_cs_n, e.rdata);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    m_bank = 9'd1; m_ramb = 4'd0; m_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(16'h4000, "R1 reset bank 1");
    rd(16'hA000, "R1 R8 reset ram off");
    rd(16'h1234, "R5 R9 fixed window");
    wr(16'h2000, 8'h5A);
    rd(16'h7FFF, "R2 low byte");
    wr(16'h3000, 8'hFF);
    rd(16'h4001, "R3 high bit set");
    wr(16'h3FFF, 8'h02);
    rd(16'h5000, "R3 only data bit 0");
    wr(16'h2FFF, 8'h00);
    wr(16'h3000, 8'h00);
    rd(16'h4000, "R4 bank 0 kept");
    wr(16'h2000, 8'hFF);
    wr(16'h3000, 8'h01);
    rd(16'h3FFF, "R5 zero with bank 1FF");
    rd(16'h6ABC, "R2 R3 bank 1FF");
    wr(16'h4000, 8'h0F);
    rd(16'h0000, "R6 ram bank F");
    wr(16'h5FFF, 8'h13);
    rd(16'h0100, "R6 upper data ignored");
    wr(16'h6000, 8'h00);
    wr(16'h7FFF, 8'h0A);
    wr(16'h9000, 8'h0A);
    rd(16'h4000, "R9 no effect of 6000-7FFF and 8000+ writes");
    rd(16'hA000, "R9 R8 RAM still off");
    wr(16'h0000, 8'h0B);
    rd(16'hB000, "R7 wrong key");
    wr(16'h1FFF, 8'h0A);
    rd(16'hA123, "R7 R8 key enables");
    rd(16'h8000, "R9 no ROM select above 7FFF");
    wr(16'h0000, 8'h8A);
    rd(16'hBFFF, "R7 other byte disables");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule